// File: doc/BRIEF.md
# Serial Flash Page-Write Host Sequencer

This block writes a buffer of any length from a byte source into a serial NOR flash over a four-wire serial master link (clock, select, data out, data in). A single start pulse supplies a start address and a byte count. The block cuts the transfer into pieces that never cross a 256-byte page. For each piece it sends a write-enable command, then a program command that carries the address and the data. It then raises select and polls the flash status register until the write-in-progress flag clears, and only after that does it move to the next piece.

Data bytes are pulled from the source one at a time with a request/acknowledge pair, exactly when the serial engine needs them, so the source needs no buffering. The serial clock is the system clock divided by a parameter. Bits are launched after the falling edge and sampled by the flash on the rising edge, and the clock idles low. Between commands, select is held high for a parameterised minimum number of cycles. Busy covers the whole transfer, and a one-cycle done pulse ends it.

Top module: `sflash_page_writer`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, and busy_o, done_o and req_o are 0.
- R2: Each program command (first byte 0x02) is immediately preceded by its own write-enable command (single byte 0x06). Per piece the command order is 0x06, 0x02, then one or more status reads.
- R3: A program command is the byte 0x02, then the address as three bytes with the high byte first, then the data bytes. Every byte is sent most significant bit first. The clock idles low, and data out is stable at every rising clock edge.
- R4: The first piece holds min(count, 256 − addr[7:0]) bytes. Each later piece starts on a 256-byte boundary and holds min(remaining, 256) bytes. No program command crosses a page. The address wraps modulo 2^24.
- R5: Every command ends on a byte boundary. Select rises no more than CLK_DIV+2 cycles after the last rising clock edge of the command.
- R6: Status is read with command 0x05 followed by one dummy byte, and bit 0 of the returned byte is write-in-progress. Reads repeat, each as its own command, until bit 0 is 0. Bits 7..1 are ignored.
- R7: Select stays high for at least GAP_CYC clock cycles between any two commands.
- R8: Data is taken from the source only when req_o and ack_i are both high, one byte per such cycle. Exactly count bytes are taken, and byte i lands at address start+i.
- R9: done_o is a one-cycle pulse in the same cycle that select rises after the last status read that returns bit 0 = 0. busy_o is high from the cycle after a start until done_o, and is low while done_o is high.
- R10: A start with count 0 produces a done_o pulse and no select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| addr_i | input | 8*ADDR_BYTES | Flash start address |
| count_i | input | CNT_W | Number of bytes to write |
| req_o | output | 1 | Next data byte wanted |
| ack_i | input | 1 | Source presents data_i this cycle |
| data_i | input | 8 | Data byte from the source |
| sck_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Flash select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach from the ports is a transfer that starts mid-page, spans several pages and wraps past the top of the address space, while the flash keeps reporting write-in-progress for several status reads after each program. The bench gets there with a behavioural flash model that decodes commands from the serial pins. The model keeps a write-enable latch and a count of busy polls, and answers status reads with a byte whose upper bits are set, so a wrong bit choice shows up as a hang. Start addresses such as 0x0300FE and 0xFFFFF8 force short first pieces and the wrap, and a source that delays its acknowledge stretches the data phase.

// File: rtl/sfpw_pkg.sv
`timescale 1ns/1ps
// Shared constants and state encoding for the page-write sequencer.
// Assumes a flash that uses the common single-byte command set.
package sfpw_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_DUMMY = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_PLAN,
        ST_WREN,
        ST_HDR,
        ST_REQ,
        ST_DAT,
        ST_RDSR,
        ST_STAT
    } seq_st_t;
endpackage

// File: rtl/sfpw_chunk_calc.sv
`timescale 1ns/1ps
// Piece-length calculator: min(remaining, bytes left in the current page).
// Assumes CNT_W > PAGE_W so that a full page length fits the count.
module sfpw_chunk_calc #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 24,
    parameter int PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  remain_i,
    output logic [PAGE_W:0]   len_o
);
    localparam logic [PAGE_W:0] PAGE_BYTES = {1'b1, {PAGE_W{1'b0}}};

    logic [PAGE_W:0] room;

    // Purpose: bytes from the address up to the end of its page, clipped by remainder.
    always_comb begin
        room = PAGE_BYTES - {1'b0, addr_i[PAGE_W-1:0]};
        if (remain_i >= CNT_W'(room)) len_o = room;
        else                          len_o = remain_i[PAGE_W:0];
    end
endmodule

// File: rtl/sfpw_byte_shifter.sv
`timescale 1ns/1ps
// Serial byte engine, clock idle low, data launched after the falling edge
// and captured on the rising edge. One go pulse moves one byte each way.
// Assumes go_i only arrives while the engine is idle; select is owned by the caller.
module sfpw_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic [7:0] rx_o,
    output logic       done_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

    logic          act_q;
    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sr_q;
    logic [7:0]    rx_q;
    logic          sck_q;
    logic          done_q;

    // Purpose: half-period timing, bit shifting and capture of the returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            sr_q   <= '0;
            rx_q   <= '0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && !act_q) begin
                act_q <= 1'b1;
                sr_q  <= tx_i;
                bit_q <= '0;
                div_q <= '0;
                sck_q <= 1'b0;
            end else if (act_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[6:0], miso_i};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            act_q  <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sr_q  <= {sr_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + CW'(1);
                end
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = sr_q[7];
    assign rx_o   = rx_q;
    assign done_o = done_q;
endmodule

// File: rtl/sfpw_ctrl.sv
`timescale 1ns/1ps
// Command sequencer: per page piece it runs write-enable, program (address
// and data pulled from the source) and status polling, with a minimum
// select-high gap before every command.
// Assumes the byte engine returns one done pulse per go pulse.
module sfpw_ctrl
    import sfpw_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int CNT_W      = 24,
    parameter int PAGE_W     = 8,
    parameter int GAP_CYC    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic [CNT_W-1:0]        count_i,
    output logic                    req_o,
    input  logic                    ack_i,
    input  logic [7:0]              data_i,
    output logic                    sh_go_o,
    output logic [7:0]              sh_tx_o,
    input  logic                    sh_done_i,
    input  logic [7:0]              sh_rx_i,
    output logic                    cs_n_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [8*ADDR_BYTES-1:0] cur_addr_o,
    output logic [CNT_W-1:0]        remain_o,
    input  logic [PAGE_W:0]         chunk_len_i
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int GW     = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam int IW     = $clog2(ADDR_BYTES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [IW-1:0] HDR_END  = IW'(ADDR_BYTES);

    seq_st_t           st_q, ret_q;
    logic              cs_n_q, go_q, done_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [PAGE_W:0]   len_q, left_q;
    logic [IW-1:0]     hdr_q;
    logic [GW-1:0]     gap_q;
    logic [7:0]        hdr_byte;

    // Purpose: pick the address byte for the current header position, high byte first.
    always_comb begin
        hdr_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (int'(hdr_q) == k) hdr_byte = addr_q[8*(ADDR_BYTES-1-k) +: 8];
    end

    // Purpose: main state machine with registered select, engine launch and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ret_q  <= ST_PLAN;
            cs_n_q <= 1'b1;
            go_q   <= 1'b0;
            done_q <= 1'b0;
            tx_q   <= '0;
            addr_q <= '0;
            rem_q  <= '0;
            len_q  <= '0;
            left_q <= '0;
            hdr_q  <= '0;
            gap_q  <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    addr_q <= addr_i;
                    rem_q  <= count_i;
                    ret_q  <= ST_PLAN;
                    gap_q  <= '0;
                    st_q   <= ST_GAP;
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        unique case (ret_q)
                            ST_HDR: begin
                                cs_n_q <= 1'b0;
                                go_q   <= 1'b1;
                                tx_q   <= OP_PROG;
                                hdr_q  <= '0;
                                st_q   <= ST_HDR;
                            end
                            ST_RDSR: begin
                                cs_n_q <= 1'b0;
                                go_q   <= 1'b1;
                                tx_q   <= OP_RDSR;
                                st_q   <= ST_RDSR;
                            end
                            default: st_q <= ST_PLAN;
                        endcase
                    end else begin
                        gap_q <= gap_q + GW'(1);
                    end
                end
                ST_PLAN: begin
                    if (rem_q == '0) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        len_q  <= chunk_len_i;
                        left_q <= chunk_len_i;
                        cs_n_q <= 1'b0;
                        go_q   <= 1'b1;
                        tx_q   <= OP_WREN;
                        st_q   <= ST_WREN;
                    end
                end
                ST_WREN: if (sh_done_i) begin
                    cs_n_q <= 1'b1;
                    gap_q  <= '0;
                    ret_q  <= ST_HDR;
                    st_q   <= ST_GAP;
                end
                ST_HDR: if (sh_done_i) begin
                    if (hdr_q != HDR_END) begin
                        go_q  <= 1'b1;
                        tx_q  <= hdr_byte;
                        hdr_q <= hdr_q + IW'(1);
                    end else begin
                        st_q <= ST_REQ;
                    end
                end
                ST_REQ: if (ack_i) begin
                    go_q   <= 1'b1;
                    tx_q   <= data_i;
                    left_q <= left_q - 1'b1;
                    st_q   <= ST_DAT;
                end
                ST_DAT: if (sh_done_i) begin
                    if (left_q == '0) begin
                        cs_n_q <= 1'b1;
                        gap_q  <= '0;
                        ret_q  <= ST_RDSR;
                        st_q   <= ST_GAP;
                    end else begin
                        st_q <= ST_REQ;
                    end
                end
                ST_RDSR: if (sh_done_i) begin
                    go_q <= 1'b1;
                    tx_q <= OP_DUMMY;
                    st_q <= ST_STAT;
                end
                ST_STAT: if (sh_done_i) begin
                    cs_n_q <= 1'b1;
                    gap_q  <= '0;
                    if (sh_rx_i[0]) begin
                        ret_q <= ST_RDSR;
                        st_q  <= ST_GAP;
                    end else begin
                        addr_q <= addr_q + ADDR_W'(len_q);
                        rem_q  <= rem_q - CNT_W'(len_q);
                        if (rem_q == CNT_W'(len_q)) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            ret_q <= ST_PLAN;
                            st_q  <= ST_GAP;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_o      = (st_q == ST_REQ);
    assign sh_go_o    = go_q;
    assign sh_tx_o    = tx_q;
    assign cs_n_o     = cs_n_q;
    assign busy_o     = (st_q != ST_IDLE);
    assign done_o     = done_q;
    assign cur_addr_o = addr_q;
    assign remain_o   = rem_q;
endmodule

// File: rtl/sflash_page_writer.sv
`timescale 1ns/1ps
// Top of the page-write sequencer: joins the command sequencer, the
// piece-length calculator and the serial byte engine.
// Assumes CLK_DIV >= 1, GAP_CYC >= 1 and CNT_W > PAGE_W.
module sflash_page_writer #(
    parameter int CLK_DIV    = 2,
    parameter int GAP_CYC    = 3,
    parameter int ADDR_BYTES = 3,
    parameter int CNT_W      = 24,
    parameter int PAGE_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic [CNT_W-1:0]        count_i,
    output logic                    req_o,
    input  logic                    ack_i,
    input  logic [7:0]              data_i,
    output logic                    sck_o,
    output logic                    cs_n_o,
    output logic                    mosi_o,
    input  logic                    miso_i,
    output logic                    busy_o,
    output logic                    done_o
);
    localparam int ADDR_W = 8 * ADDR_BYTES;

    logic              sh_go, sh_done;
    logic [7:0]        sh_tx, sh_rx;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic [PAGE_W:0]   chunk_len;

    sfpw_ctrl #(
        .ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .GAP_CYC(GAP_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .count_i(count_i), .req_o(req_o), .ack_i(ack_i), .data_i(data_i),
        .sh_go_o(sh_go), .sh_tx_o(sh_tx), .sh_done_i(sh_done), .sh_rx_i(sh_rx),
        .cs_n_o(cs_n_o), .busy_o(busy_o), .done_o(done_o),
        .cur_addr_o(cur_addr), .remain_o(remain), .chunk_len_i(chunk_len)
    );

    sfpw_chunk_calc #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)
    ) u_chunk (
        .addr_i(cur_addr), .remain_i(remain), .len_o(chunk_len)
    );

    sfpw_byte_shifter #(
        .HALF_DIV(CLK_DIV)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .go_i(sh_go), .tx_i(sh_tx), .miso_i(miso_i),
        .sck_o(sck_o), .mosi_o(mosi_o), .rx_o(sh_rx), .done_o(sh_done)
    );
endmodule

// File: rtl/sfpw_checker.sv
`timescale 1ns/1ps
// Protocol checker for the page-write sequencer, attached to the top by bind.
// Assumes the same GAP_CYC as the bound instance.
module sfpw_checker #(
    parameter int GAP_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic req_o,
    input logic sck_o,
    input logic cs_n_o,
    input logic mosi_o,
    input logic busy_o,
    input logic done_o
);
    logic [15:0] hi_cnt;

    // Purpose: count consecutive select-high cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            hi_cnt <= '0;
        else if (!cs_n_o)      hi_cnt <= '0;
        else if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
    end

    p_idle_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);
    p_clock_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);
    p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(mosi_o));
    p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && hi_cnt != 16'd0) |-> (hi_cnt >= 16'(GAP_CYC)));
    p_req_in_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !cs_n_o);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

bind sflash_page_writer sfpw_checker #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_o(req_o), .sck_o(sck_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_sflash_page_writer.sv
`timescale 1ns/1ps
// Directed bench with a behavioural flash model decoded from the serial pins.
module sim_sflash_page_writer;
    localparam int CLK_DIV = 2;
    localparam int GAP_CYC = 3;
    localparam int WIP_N   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] addr = '0;
    logic [23:0] count = '0;
    logic        req, sck, cs_n, mosi, busy, done;
    logic        ack = 1'b0;
    logic [7:0]  data = '0;
    logic        miso = 1'b0;

    int n_chk = 0, n_bad = 0;

    sflash_page_writer #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .count_i(count),
        .req_o(req), .ack_i(ack), .data_i(data), .sck_o(sck), .cs_n_o(cs_n),
        .mosi_o(mosi), .miso_i(miso), .busy_o(busy), .done_o(done)
    );

    always #10 clk = ~clk;

    // Model and monitor state
    logic [7:0]  fmem [logic [23:0]];
    logic [7:0]  cur [$];
    logic [7:0]  opq [$];
    logic [23:0] pg_a [$];
    int          pg_n [$];
    int cyc = 0, done_cnt = 0, done_cyc = 0, busy_err = 0, cs_falls = 0;
    int high_cnt = 0, min_gap = 1000000, bitcnt = 0, last_rise = 0, rel_max = 0;
    int last_cs_rise = 0, align_err = 0, prot_err = 0, polls = 0, wip_left = 0;
    int src_idx = 0, src_lat = 0, src_wait = 0, reqs = 0, seed = 0;
    logic wel = 1'b0, prev_cs = 1'b1, prev_sck = 1'b0;
    logic [7:0] shreg = '0;

    function automatic logic [7:0] srcb(input int i);
        return 8'((i * 37 + 11 + seed) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic end_cmd();
        logic [23:0] a;
        int n;
        if (bitcnt % 8 != 0) align_err++;
        if (bitcnt > 0 && cyc - last_rise > rel_max) rel_max = cyc - last_rise;
        if (cur.size() == 0) return;
        opq.push_back(cur[0]);
        if (wip_left > 0 && cur[0] != 8'h05) prot_err++;
        case (cur[0])
            8'h06: wel = 1'b1;
            8'h02: begin
                if (!wel || cur.size() < 5) prot_err++;
                a = {cur[1], cur[2], cur[3]};
                n = cur.size() - 4;
                if (int'(a[7:0]) + n > 256) prot_err++;
                for (int j = 0; j < n; j++) fmem[{a[23:8], 8'(int'(a[7:0]) + j)}] = cur[4+j];
                pg_a.push_back(a);
                pg_n.push_back(n);
                wel = 1'b0;
                wip_left = WIP_N;
            end
            8'h05: begin
                polls++;
                if (wip_left > 0) wip_left--;
            end
            default: prot_err++;
        endcase
    endtask

    // Monitor, flash model and byte source, all sampled away from the active edge
    always @(negedge clk) begin
        logic [7:0] stat;
        cyc++;
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (!cs_n && !busy) busy_err++;
        if (ack) begin
            ack = 1'b0;
            src_idx++;
            reqs++;
        end else if (req) begin
            if (src_wait >= src_lat) begin
                ack = 1'b1;
                data = srcb(src_idx);
                src_wait = 0;
            end else src_wait++;
        end
        if (prev_cs && !cs_n) begin
            cs_falls++;
            if (high_cnt < min_gap) min_gap = high_cnt;
            bitcnt = 0;
            cur.delete();
            shreg = '0;
            miso = 1'b0;
        end
        if (cs_n) high_cnt++; else high_cnt = 0;
        if (!cs_n && !prev_sck && sck) begin
            shreg = {shreg[6:0], mosi};
            bitcnt++;
            last_rise = cyc;
            if (bitcnt % 8 == 0) cur.push_back(shreg);
        end
        if (!cs_n && prev_sck && !sck && cur.size() >= 1 && cur[0] == 8'h05 && bitcnt >= 8) begin
            stat = {7'b1010101, (wip_left > 0)};
            miso = stat[7 - (bitcnt % 8)];
        end
        if (!prev_cs && cs_n) begin
            last_cs_rise = cyc;
            end_cmd();
        end
        prev_cs = cs_n;
        prev_sck = sck;
    end

    task automatic clear_model();
        fmem.delete(); opq.delete(); pg_a.delete(); pg_n.delete();
        done_cnt = 0; busy_err = 0; cs_falls = 0; min_gap = 1000000; rel_max = 0;
        align_err = 0; prot_err = 0; polls = 0; wip_left = 0; wel = 1'b0;
        src_idx = 0; src_wait = 0; reqs = 0;
    endtask

    task automatic run_xfer(input logic [23:0] a0, input int cnt, input int lat, input int sd);
        logic [23:0] ea [$];
        int en [$];
        logic [23:0] a;
        int r, n, mism, ordbad;
        logic [7:0] exp_op [$];
        clear_model();
        src_lat = lat;
        seed = sd;
        a = a0; r = cnt;
        while (r > 0) begin
            n = 256 - int'(a[7:0]);
            if (r < n) n = r;
            ea.push_back(a); en.push_back(n);
            a = a + 24'(n);
            r -= n;
        end
        @(negedge clk);
        addr = a0; count = 24'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == 0) @(negedge clk);
        repeat (12) @(negedge clk);
        // R4: piece split
        chk(pg_a.size() == ea.size(), "R4 piece count", pg_a.size(), ea.size());
        mism = 0;
        for (int i = 0; i < ea.size() && i < pg_a.size(); i++)
            if (pg_a[i] != ea[i] || pg_n[i] != en[i]) mism++;
        chk(mism == 0, "R4 piece address/length mismatches", mism, 0);
        // R8 and R3: bytes taken and where they landed
        chk(reqs == cnt, "R8 bytes taken from source", reqs, cnt);
        mism = 0;
        for (int i = 0; i < cnt; i++) begin
            a = a0 + 24'(i);
            if (!fmem.exists(a) || fmem[a] != srcb(i)) mism++;
        end
        chk(mism == 0, "R3 R8 data/address mismatches", mism, 0);
        chk(prot_err == 0, "R3 protocol errors", prot_err, 0);
        // R2 and R6: command order with polls
        for (int i = 0; i < ea.size(); i++) begin
            exp_op.push_back(8'h06); exp_op.push_back(8'h02);
            for (int k = 0; k <= WIP_N; k++) exp_op.push_back(8'h05);
        end
        ordbad = (opq.size() != exp_op.size()) ? 1 : 0;
        for (int i = 0; i < exp_op.size() && i < opq.size(); i++)
            if (opq[i] != exp_op[i]) ordbad++;
        chk(ordbad == 0, "R2 command order errors", ordbad, 0);
        chk(polls == ea.size() * (WIP_N + 1), "R6 status reads", polls, ea.size() * (WIP_N + 1));
        // R5: byte-aligned ends and prompt release
        chk(align_err == 0, "R5 unaligned command ends", align_err, 0);
        chk(rel_max <= CLK_DIV + 2, "R5 release delay", rel_max, CLK_DIV + 2);
        // R7: select gap
        chk(min_gap >= GAP_CYC, "R7 minimum select gap", min_gap, GAP_CYC);
        // R9: done and busy
        chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        chk(done_cyc - last_cs_rise >= 0 && done_cyc - last_cs_rise <= 1,
            "R9 done after final poll", done_cyc - last_cs_rise, 0);
        chk(busy_err == 0 && !busy, "R9 busy coverage", busy_err, 0);
    endtask

    task automatic t_reset();
        chk(cs_n === 1'b1, "R1 cs_n after reset", cs_n, 1);
        chk(sck === 1'b0, "R1 sck after reset", sck, 0);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(done === 1'b0, "R1 done after reset", done, 0);
        chk(req === 1'b0, "R1 req after reset", req, 0);
    endtask

    task automatic t_aligned_short();  run_xfer(24'h001000, 5, 0, 1);   endtask
    task automatic t_cross_page();     run_xfer(24'h0120F0, 40, 2, 2);  endtask
    task automatic t_multi_page();     run_xfer(24'h0300FE, 300, 1, 3); endtask
    task automatic t_full_page();      run_xfer(24'h040000, 256, 0, 4); endtask
    task automatic t_addr_wrap();      run_xfer(24'hFFFFF8, 16, 3, 5);  endtask

    task automatic t_zero_count();
        clear_model();
        @(negedge clk);
        addr = 24'h000123; count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (GAP_CYC + 10) @(negedge clk);
        chk(done_cnt == 1, "R10 done pulse on zero count", done_cnt, 1);
        chk(cs_falls == 0, "R10 no select activity", cs_falls, 0);
        chk(reqs == 0, "R10 no source requests", reqs, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned_short();
        t_cross_page();
        t_multi_page();
        t_full_page();
        t_addr_wrap();
        t_zero_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule